// File: doc/BRIEF.md
# Late-Write Byte-Lane Parity Checker

This block sits beside the write path of a synchronous memory whose data bus is split into 9-bit byte lanes. Each lane carries eight data bits and one parity bit in its top position. A write command is accepted with a per-lane byte-write mask. The data for that write arrives later on the same bus, either one edge after the command (flow-through timing) or two edges after it (pipelined timing). The block keeps the command's mask in step with that data latency. At the edge where the data is captured, it checks only the lanes that the mask enabled.

A static input sets the parity sense to even or odd. A second static input sets the timing mode. A stall input freezes the whole pipeline for one edge at a time. Any checked lane with wrong parity pulls the active-low, open-drain-style error output low for the one cycle after the capture edge. At all other times the output is released (driven 1). The lane count is a parameter, and 2 or 4 lanes are the intended settings.

Top module: `wr_parity_chk`

## Requirements
- R1: After reset, and until a bad capture occurs, `err_n` is 1 (released).
- R2: With `flow_thru`=0, a write accepted at edge k has its data checked at edge k+2, counting only edges where `hold`=0. `err_n` reflects that check during the cycle after edge k+2.
- R3: With `flow_thru`=1, a write accepted at edge k has its data checked at edge k+1, counting only edges where `hold`=0.
- R4: With `par_even`=1, a lane is correct when its 9 bits (data bits [7:0] plus parity bit [8] of the lane) hold an even number of ones.
- R5: With `par_even`=0, a lane is correct when its 9 bits hold an odd number of ones.
- R6: Only lanes whose `cmd_be` bit was 1 in the write command are checked. Lane i occupies `wr_data[9*i+8:9*i]`, and bad parity on a disabled lane does not pull `err_n` low.
- R7: A write command with `cmd_be` all zero (abort) never pulls `err_n` low, whatever data appears at its capture edge.
- R8: Bus data at edges where no write capture is due is ignored, and `err_n` stays 1 after such edges.
- R9: An edge with `hold`=1 neither accepts a command nor advances or captures. `err_n` is 1 in the cycle after a hold edge.
- R10: `err_n` is low for exactly one cycle per bad capture. Back-to-back writes are each checked independently against their own data.
- R11: A parity error on any single enabled lane is enough to pull `err_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_thru | input | 1 | Static timing mode: 1 = data one edge after the command, 0 = two edges after |
| par_even | input | 1 | Static parity sense: 1 = even, 0 = odd |
| hold | input | 1 | Stall: an edge with 1 is ignored by the whole block |
| cmd_wr | input | 1 | Write command accepted at this edge |
| cmd_be | input | LANES | Per-lane byte-write enables of the command, active high |
| wr_data | input | 9*LANES | Write data bus, lane i at bits [9*i+8:9*i], parity in bit 8 of each lane |
| err_n | output | 1 | Parity error, active low, open-drain style (1 = released) |

## Verification
A write's verdict appears on `err_n` in the cycle after its capture edge. That is two non-stalled edges after the command in pipelined mode and one in flow-through mode, and every stall edge adds one more. The bench drives inputs and samples on falling edges. It counts edges from the command to the capture edge by hand for each scenario, and checks `err_n` in the cycle right after that edge and again in the cycle after that to confirm the one-cycle pulse. Between command and capture, and at stall edges, the bus carries data with bad parity in every lane. Any capture at the wrong edge therefore shows up as a wrong `err_n` value.

// File: rtl/wpar_pkg.sv
package wpar_pkg;
  localparam int LANE_W = 9;

  // True when a 9-bit lane matches the selected parity sense.
  function automatic logic lane_par_ok(input logic [LANE_W-1:0] lane, input logic even_sel);
    return (^lane) == ~even_sel;
  endfunction
endpackage

// File: rtl/wpar_ctl_pipe.sv
module wpar_ctl_pipe #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             flow_thru,
  input  logic             cmd_wr,
  input  logic [LANES-1:0] cmd_be,
  output logic             cap_vld,
  output logic [LANES-1:0] cap_be
);
  logic             s1_vld, s2_vld;
  logic [LANES-1:0] s1_be, s2_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_be  <= '0;
      s2_vld <= 1'b0;
      s2_be  <= '0;
    end else if (!hold) begin
      s1_vld <= cmd_wr;
      s1_be  <= cmd_be;
      s2_vld <= s1_vld;
      s2_be  <= s1_be;
    end
  end

  // Capture stage: one edge late in flow-through, two in pipelined.
  assign cap_vld = flow_thru ? s1_vld : s2_vld;
  assign cap_be  = flow_thru ? s1_be  : s2_be;

  // R9: a stall edge leaves every stage untouched
  a_r9_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(s1_vld) && $stable(s2_vld) && $stable(s1_be) && $stable(s2_be)));
  // R2: the second stage takes the first stage's previous content
  a_r2_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> (s2_vld == $past(s1_vld) && s2_be == $past(s1_be)));
endmodule

// File: rtl/wpar_lane_chk.sv
module wpar_lane_chk
  import wpar_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    even_sel,
  input  logic [LANES-1:0]        lane_en,
  output logic [LANES-1:0]        lane_bad
);
  logic [LANES-1:0] lane_mis;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mis[i] = ~lane_par_ok(wr_data[i*LANE_W +: LANE_W], even_sel);
    assign lane_bad[i] = lane_en[i] & lane_mis[i];
  end
endmodule

// File: rtl/wr_parity_chk.sv
module wr_parity_chk
  import wpar_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_thru,
  input  logic                    par_even,
  input  logic                    hold,
  input  logic                    cmd_wr,
  input  logic [LANES-1:0]        cmd_be,
  input  logic [LANES*LANE_W-1:0] wr_data,
  output logic                    err_n
);
  logic             cap_vld;
  logic [LANES-1:0] cap_be;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_bad;
  logic             capture_err;

  wpar_ctl_pipe #(.LANES(LANES)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold     (hold),
    .flow_thru(flow_thru),
    .cmd_wr   (cmd_wr),
    .cmd_be   (cmd_be),
    .cap_vld  (cap_vld),
    .cap_be   (cap_be)
  );

  assign lane_en = cap_be & {LANES{cap_vld}};

  wpar_lane_chk #(.LANES(LANES)) u_lanes (
    .wr_data (wr_data),
    .even_sel(par_even),
    .lane_en (lane_en),
    .lane_bad(lane_bad)
  );

  assign capture_err = (|lane_bad) & ~hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_n <= 1'b1;
    else        err_n <= ~capture_err;
  end

  // R8: no capture due at an edge means released afterwards
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld |=> err_n);
  // R7: an aborted write never flags
  a_r7_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && cap_be == '0) |=> err_n);
  // R9: released after a stall edge
  a_r9_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> err_n);
  // R6: a low output always traces back to a capture with enabled lanes
  a_r6_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    !err_n |-> $past(cap_vld && (|cap_be)));
endmodule

// File: tb/tb_wr_parity_chk.sv
module tb_wr_parity_chk;
  localparam int LANES = 2;
  logic clk = 1'b0;
  logic rst_n, flow_thru, par_even, hold, cmd_wr;
  logic [LANES-1:0] cmd_be;
  logic [LANES*9-1:0] wr_data;
  logic err_n;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wr_parity_chk #(.LANES(LANES)) dut (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .par_even(par_even),
    .hold(hold), .cmd_wr(cmd_wr), .cmd_be(cmd_be), .wr_data(wr_data), .err_n(err_n)
  );

  // Build one lane: parity bit chosen by counting ones, then spoiled if bad.
  function automatic logic [8:0] mk_lane(input logic [7:0] d, input bit even, input bit good);
    int ones = 0;
    logic p;
    for (int b = 0; b < 8; b++) ones += d[b];
    p = even ? (ones % 2 == 1) : (ones % 2 == 0);
    if (!good) p = ~p;
    return {p, d};
  endfunction

  function automatic logic [17:0] mk_word(input bit even, input bit g0, input bit g1);
    return {mk_lane(8'hC3, even, g1), mk_lane(8'h5A, even, g0)};
  endfunction

  // Junk bus: every lane wrong for the current sense.
  function automatic logic [17:0] junk();
    return mk_word(par_even, 1'b0, 1'b0);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic exp, input string req);
    n_tests++;
    if (err_n !== exp) begin
      n_fail++;
      $display("FAIL %s: err_n=%b expected %b", req, err_n, exp);
    end
  endtask

  // One write: command, latency by mode, capture, then two observed cycles.
  task automatic do_write(input logic [1:0] be, input logic [17:0] d, input logic exp_low, input string req);
    cmd_wr = 1'b1; cmd_be = be; wr_data = junk();
    tick();
    cmd_wr = 1'b0; cmd_be = '0;
    if (!flow_thru) tick();
    wr_data = d;
    tick();
    chk(~exp_low, req);
    wr_data = junk();
    tick();
    chk(1'b1, {req, " release"});
  endtask

  task automatic t_reset();
    chk(1'b1, "R1 reset");
  endtask

  task automatic t_pipe_even();
    flow_thru = 1'b0; par_even = 1'b1;
    do_write(2'b11, mk_word(1, 0, 1), 1'b1, "R2 R4 R11 pipelined even lane0 bad");
    do_write(2'b11, mk_word(1, 1, 1), 1'b0, "R4 even good");
  endtask

  task automatic t_pipe_odd();
    flow_thru = 1'b0; par_even = 1'b0;
    do_write(2'b11, mk_word(0, 1, 1), 1'b0, "R5 odd good");
    do_write(2'b11, mk_word(0, 1, 0), 1'b1, "R5 R11 odd lane1 bad");
  endtask

  task automatic t_flow();
    flow_thru = 1'b1; par_even = 1'b1;
    do_write(2'b11, mk_word(1, 0, 1), 1'b1, "R3 flow bad");
    do_write(2'b11, mk_word(1, 1, 1), 1'b0, "R3 flow good");
  endtask

  task automatic t_lane_mask();
    flow_thru = 1'b0; par_even = 1'b1;
    do_write(2'b01, mk_word(1, 1, 0), 1'b0, "R6 disabled lane1 bad");
    do_write(2'b10, mk_word(1, 0, 1), 1'b0, "R6 disabled lane0 bad");
  endtask

  task automatic t_abort();
    flow_thru = 1'b1; par_even = 1'b0;
    do_write(2'b00, mk_word(0, 0, 0), 1'b0, "R7 abort flow");
    flow_thru = 1'b0;
    do_write(2'b00, mk_word(0, 0, 0), 1'b0, "R7 abort pipelined");
  endtask

  task automatic t_idle_bus();
    cmd_wr = 1'b0; wr_data = junk();
    tick(); tick();
    chk(1'b1, "R8 idle bus ignored");
  endtask

  task automatic t_hold();
    // pipelined: one stall edge pushes capture one edge later
    flow_thru = 1'b0; par_even = 1'b1;
    cmd_wr = 1'b1; cmd_be = 2'b11; wr_data = junk();
    tick();
    cmd_wr = 1'b0; hold = 1'b1;
    tick();
    chk(1'b1, "R9 hold edge released");
    hold = 1'b0;
    tick();
    chk(1'b1, "R9 R2 no early capture");
    wr_data = mk_word(1, 1, 0);
    tick();
    chk(1'b0, "R9 R2 delayed capture flags");
    wr_data = junk();
    tick();
    chk(1'b1, "R9 release");
    // flow: bad data on a hold edge is not captured
    flow_thru = 1'b1;
    cmd_wr = 1'b1; cmd_be = 2'b11;
    tick();
    cmd_wr = 1'b0; hold = 1'b1;
    tick();
    chk(1'b1, "R9 flow bad data at hold ignored");
    hold = 1'b0; wr_data = mk_word(1, 1, 1);
    tick();
    chk(1'b1, "R9 R3 flow capture after hold good");
    wr_data = junk();
  endtask

  task automatic t_back_to_back();
    flow_thru = 1'b0; par_even = 1'b0;
    cmd_wr = 1'b1; cmd_be = 2'b10; wr_data = junk();
    tick();
    cmd_be = 2'b11;
    tick();
    cmd_wr = 1'b0; cmd_be = '0;
    wr_data = mk_word(0, 0, 0);
    tick();
    chk(1'b0, "R10 first of pair bad");
    wr_data = mk_word(0, 1, 1);
    tick();
    chk(1'b1, "R10 second of pair good");
    wr_data = junk();
    tick();
    chk(1'b1, "R10 pair released");
  endtask

  initial begin
    rst_n = 1'b0; flow_thru = 1'b0; par_even = 1'b1; hold = 1'b0;
    cmd_wr = 1'b0; cmd_be = '0; wr_data = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_pipe_even();
    t_pipe_odd();
    t_flow();
    t_lane_mask();
    t_abort();
    t_idle_bus();
    t_hold();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule